// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit byte address for a small 16-bit processor model. It holds four segment registers: code, data, extra and stack. From the kind of each access it picks which register supplies the base. The base is shifted left by four bits and the offset is added, with the sum wrapping inside a 1 MB space.

A word access at an even offset goes out as one 16-bit bus cycle. A word at an odd offset goes out as two byte cycles, lower address first. The address of the upper byte is formed from the offset plus one, wrapped within 16 bits. A data access may name a different segment through an override input.

The code segment is loaded only through a dedicated jump path and comes out of reset at a fixed value. The other three segments are loaded through a general write port.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, busValid is 0, reqReady is 1, the code segment holds CS_RESET (default 16'hFFFF) and the data, extra and stack segments hold 0.
- R2: A bus address equals (segment << 4) + zero-extended offset, taken modulo 2^20.
- R3: With no override, reqKind selects the segment as follows: 0 (fetch) uses code, 1 (data) uses data, 2 (stack) uses stack and 3 (string destination) uses extra.
- R4: When ovrEn is 1 on a data access (reqKind 1), ovrSel replaces the default segment, with 0 = code, 1 = data, 2 = extra and 3 = stack. For reqKind 0, 2 and 3 the override has no effect.
- R5: segWrEn loads segWrData into the segment named by segWrSel (same encoding as ovrSel). A write with segWrSel = 0 (code) changes nothing.
- R6: csLoadEn loads csLoadData into the code segment. This is the only way to change the code segment after reset.
- R7: A byte access (reqWord 0), or a word access at an even offset, produces exactly one beat. The beat comes the cycle after acceptance, with busLast = 1 and busWide = reqWord.
- R8: A word access at an odd offset produces two consecutive byte beats (busWide 0). The first beat is at the address of the offset and has busLast 0. The second beat is at the address of (offset+1) mod 2^16 and has busLast 1.
- R9: reqReady is 0 during the cycle in which the first beat of a split word is shown. A request presented in that cycle is ignored.
- R10: The segment value is captured when a request is accepted. A segment write made between the two beats of a split word does not change the second beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | General segment write strobe |
| segWrSel | input | 2 | Segment to write (0 code, ignored; 1 data; 2 extra; 3 stack) |
| segWrData | input | 16 | Value to write |
| csLoadEn | input | 1 | Code segment load from the jump path |
| csLoadData | input | 16 | New code segment value |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Request accepted this cycle when high |
| reqKind | input | 2 | 0 fetch, 1 data, 2 stack, 3 string destination |
| reqOffset | input | 16 | Offset within the segment |
| reqWord | input | 1 | 1 word access, 0 byte access |
| ovrEn | input | 1 | Segment override for data accesses |
| ovrSel | input | 2 | Override segment |
| busValid | output | 1 | Bus beat valid |
| busAddr | output | 20 | Byte address of the beat |
| busWide | output | 1 | Beat is a 16-bit cycle |
| busLast | output | 1 | Final beat of the access |

## Verification
The hardest case to reach is a split word whose second half wraps. This needs an odd-aligned word at offset 16'hFFFF, with the sum also crossing the top of the 1 MB space. Another case needs a segment write or a competing request to land exactly in the one cycle between the two beats. Directed sequences set a segment to 16'hFFFF and issue that word, and they drive a write and a junk request during the not-ready cycle. Random accesses over all kinds, sizes and override settings, mixed with random writes on both load paths, cover the selection logic.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH  = 2'd0,
    KIND_DATA   = 2'd1,
    KIND_STACK  = 2'd2,
    KIND_STRDST = 2'd3
  } accKind_t;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_STACK = 2'd3
  } segIdx_t;

  typedef struct packed {
    logic acceptFirst;
    logic issueSecond;
    logic firstWide;
    logic split;
  } ctrlStrobes_t;
endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWord,
  input  logic         reqOddLsb,
  output logic         reqReady,
  output ctrlStrobes_t strobes
);
  logic pendSecond;
  logic accept;
  logic needSplit;

  assign needSplit = reqWord && reqOddLsb;
  assign accept    = reqValid && !pendSecond;
  assign reqReady  = !pendSecond;

  always_comb begin
    strobes.acceptFirst = accept;
    strobes.issueSecond = pendSecond;
    strobes.firstWide   = reqWord && !reqOddLsb;
    strobes.split       = needSplit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendSecond <= 1'b0;
    else       pendSecond <= accept && needSplit;
  end
endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter logic [SEG_W-1:0] CS_RESET = '1,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT,
  localparam int NUM_SEG  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segWrEn,
  input  logic [1:0]        segWrSel,
  input  logic [SEG_W-1:0]  segWrData,
  input  logic              csLoadEn,
  input  logic [SEG_W-1:0]  csLoadData,
  input  logic [1:0]        reqKind,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic              ovrEn,
  input  logic [1:0]        ovrSel,
  input  ctrlStrobes_t      strobes,
  output logic              busValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWide,
  output logic              busLast
);
  logic [SEG_W-1:0] segRegs [NUM_SEG];
  logic [SEG_W-1:0] segHold;
  logic [OFF_W-1:0] offHold;
  logic [OFF_W-1:0] offNext;
  segIdx_t          selIdx;

  function automatic logic [ADDR_W-1:0] physAddr(input logic [SEG_W-1:0] s,
                                                 input logic [OFF_W-1:0] o);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ext;
    base = {s, {SEG_SHIFT{1'b0}}};
    ext  = ADDR_W'(o);
    return base + ext;
  endfunction

  always_comb begin
    unique case (accKind_t'(reqKind))
      KIND_FETCH:  selIdx = SEG_CODE;
      KIND_DATA:   selIdx = ovrEn ? segIdx_t'(ovrSel) : SEG_DATA;
      KIND_STACK:  selIdx = SEG_STACK;
      default:     selIdx = SEG_EXTRA;
    endcase
  end

  assign offNext = offHold + OFF_W'(1);

  // segment register file
  generate
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      if (g == 0) begin : g_code
        always_ff @(posedge clk) begin
          if (!rstN)         segRegs[g] <= CS_RESET;
          else if (csLoadEn) segRegs[g] <= csLoadData;
        end
      end else begin : g_gen
        always_ff @(posedge clk) begin
          if (!rstN) segRegs[g] <= '0;
          else if (segWrEn && segWrSel == 2'(g)) segRegs[g] <= segWrData;
        end
      end
    end
  endgenerate

  // beat output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busValid <= 1'b0;
      busAddr  <= '0;
      busWide  <= 1'b0;
      busLast  <= 1'b0;
      segHold  <= '0;
      offHold  <= '0;
    end else if (strobes.acceptFirst) begin
      segHold  <= segRegs[selIdx];
      offHold  <= reqOffset;
      busValid <= 1'b1;
      busAddr  <= physAddr(segRegs[selIdx], reqOffset);
      busWide  <= strobes.firstWide;
      busLast  <= !strobes.split;
    end else if (strobes.issueSecond) begin
      busValid <= 1'b1;
      busAddr  <= physAddr(segHold, offNext);
      busWide  <= 1'b0;
      busLast  <= 1'b1;
    end else begin
      busValid <= 1'b0;
      busWide  <= 1'b0;
      busLast  <= 1'b0;
    end
  end

  p_split_pair_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busLast) |=> (busValid && busLast && !busWide));

  p_second_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busLast && offHold != '1) |=> (busAddr == $past(busAddr) + ADDR_W'(1)));

  p_wide_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWide) |-> !busAddr[0]);

  p_cs_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !csLoadEn |=> (segRegs[0] == $past(segRegs[0])));

  p_ready_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueSecond |-> !strobes.acceptFirst);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter logic [SEG_W-1:0] CS_RESET = '1,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segWrEn,
  input  logic [1:0]        segWrSel,
  input  logic [SEG_W-1:0]  segWrData,
  input  logic              csLoadEn,
  input  logic [SEG_W-1:0]  csLoadData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic              reqWord,
  input  logic              ovrEn,
  input  logic [1:0]        ovrSel,
  output logic              busValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWide,
  output logic              busLast
);
  ctrlStrobes_t strobes;

  seg_addr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWord   (reqWord),
    .reqOddLsb (reqOffset[0]),
    .reqReady  (reqReady),
    .strobes   (strobes)
  );

  seg_addr_dp #(
    .SEG_W     (SEG_W),
    .OFF_W     (OFF_W),
    .SEG_SHIFT (SEG_SHIFT),
    .CS_RESET  (CS_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .segWrEn    (segWrEn),
    .segWrSel   (segWrSel),
    .segWrData  (segWrData),
    .csLoadEn   (csLoadEn),
    .csLoadData (csLoadData),
    .reqKind    (reqKind),
    .reqOffset  (reqOffset),
    .ovrEn      (ovrEn),
    .ovrSel     (ovrSel),
    .strobes    (strobes),
    .busValid   (busValid),
    .busAddr    (busAddr),
    .busWide    (busWide),
    .busLast    (busLast)
  );
endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic        csLoadEn = 1'b0;
  logic [15:0] csLoadData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = '0;
  logic [15:0] reqOffset = '0;
  logic        reqWord = 1'b0;
  logic        ovrEn = 1'b0;
  logic [1:0]  ovrSel = '0;
  logic        busValid;
  logic [19:0] busAddr;
  logic        busWide;
  logic        busLast;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen u_seg_addr_gen (.*);

  function automatic logic [19:0] expAddr(input logic [15:0] s, input logic [15:0] o);
    return ({s, 4'h0} + {4'h0, o});
  endfunction

  function automatic int expSel(input logic [1:0] k, input logic oe, input logic [1:0] os);
    case (k)
      2'd0: return 0;
      2'd1: return oe ? int'(os) : 1;
      2'd2: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic check(input string tag, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrSeg(input logic [1:0] sel, input logic [15:0] val);
    segWrEn = 1'b1; segWrSel = sel; segWrData = val;
    @(negedge clk);
    segWrEn = 1'b0;
    if (sel != 2'd0) model[sel] = val;
  endtask

  task automatic loadCs(input logic [15:0] val);
    csLoadEn = 1'b1; csLoadData = val;
    @(negedge clk);
    csLoadEn = 1'b0;
    model[0] = val;
  endtask

  // mode 0 plain, 1 junk request during gap, 2 segment write during gap
  task automatic access(input string tag, input logic [1:0] k, input logic [15:0] off,
                        input logic w, input logic oe, input logic [1:0] os, input int mode);
    logic [15:0] s;
    logic split;
    s = model[expSel(k, oe, os)];
    split = w && off[0];
    reqValid = 1'b1; reqKind = k; reqOffset = off; reqWord = w; ovrEn = oe; ovrSel = os;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " beat1 R2 R7 R8"}, {busValid, busWide, busLast, busAddr},
          {1'b1, w && !off[0], !split, expAddr(s, off)});
    if (split) begin
      check("R9 ready low in gap", {22'd0, reqReady}, 23'd0);
      if (mode == 1) begin
        reqValid = 1'b1; reqKind = 2'd1; reqOffset = 16'h0042; reqWord = 1'b0;
      end
      if (mode == 2) begin
        segWrEn = 1'b1; segWrSel = 2'(expSel(k, oe, os)); segWrData = ~s;
      end
      @(negedge clk);
      reqValid = 1'b0;
      if (mode == 2) begin
        segWrEn = 1'b0;
        if (segWrSel != 2'd0) model[segWrSel] = ~s;
      end
      check({tag, " beat2 R8 R10"}, {busValid, busWide, busLast, busAddr},
            {1'b1, 1'b0, 1'b1, expAddr(s, off + 16'd1)});
      check("R9 ready back", {22'd0, reqReady}, 23'd1);
      if (mode == 1) begin
        @(negedge clk);
        check("R9 junk ignored", {22'd0, busValid}, 23'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model[0] = 16'hFFFF; model[1] = '0; model[2] = '0; model[3] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset valid/ready", {21'd0, busValid, reqReady}, 23'd1);
    access("R1 reset code seg", 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 0);
    access("R1 reset data seg", 2'd1, 16'h0010, 1'b0, 1'b0, 2'd0, 0);
    wrSeg(2'd1, 16'h1234); wrSeg(2'd2, 16'h5678); wrSeg(2'd3, 16'h9ABC);
    access("R3 data", 2'd1, 16'h0002, 1'b1, 1'b0, 2'd0, 0);
    access("R3 stack", 2'd2, 16'h0100, 1'b1, 1'b0, 2'd0, 0);
    access("R3 strdst", 2'd3, 16'h0007, 1'b0, 1'b0, 2'd0, 0);
    access("R4 data ovr extra", 2'd1, 16'h0004, 1'b1, 1'b1, 2'd2, 0);
    access("R4 fetch ovr ignored", 2'd0, 16'h0004, 1'b1, 1'b1, 2'd1, 0);
    access("R4 stack ovr ignored", 2'd2, 16'h0006, 1'b0, 1'b1, 2'd1, 0);
    wrSeg(2'd0, 16'h4321);
    access("R5 code write ignored", 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 0);
    loadCs(16'h2000);
    access("R6 code load", 2'd0, 16'h0011, 1'b1, 1'b0, 2'd0, 0);
    wrSeg(2'd1, 16'hFFFF);
    access("R2 wrap top", 2'd1, 16'hFFFE, 1'b1, 1'b0, 2'd0, 0);
    access("R8 offset wrap split", 2'd1, 16'hFFFF, 1'b1, 1'b0, 2'd0, 0);
    access("R9 junk in gap", 2'd2, 16'h0033, 1'b1, 1'b0, 2'd0, 1);
    access("R10 write in gap", 2'd3, 16'h0101, 1'b1, 1'b0, 2'd0, 2);
    access("R10 after write", 2'd3, 16'h0101, 1'b0, 1'b0, 2'd0, 0);
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0) wrSeg(2'($urandom_range(0, 3)), 16'($urandom));
      else if (op == 1) loadCs(16'($urandom));
      else access("R2 R3 R4 random", 2'($urandom_range(0, 3)), 16'($urandom),
                  1'($urandom), 1'($urandom), 2'($urandom_range(0, 3)),
                  int'($urandom_range(0, 2)));
    end
    @(negedge clk);
    check("R7 idle after traffic", {22'd0, busValid}, 23'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule